// File: doc/BRIEF.md
# Asynchronous Tile Copy Engine

This block moves a rectangular tile of words out of a larger row-major matrix in external memory and into a banked on-chip scratchpad, without holding up the requester. A requester hands over one command carrying the source base address, the row pitch, the tile coordinates, the tile height and width, the scratchpad destination base, a barrier slot number and a swizzle enable. The command is taken in a single cycle into a two-entry queue and the requester is free to go on with other work at once.

An address walker takes queued commands in order and issues one word read per accepted handshake on a valid/ready read port. The walker starts at the tile's corner and steps through columns fastest, then rows. Read data returns in order with variable latency. The engine matches each returned word against a small in-flight tag queue holding the scratchpad address and barrier slot, and writes it into the scratchpad in the same cycle. The destination column can be XOR-permuted by the row index, which spreads a column walk across banks.

Each barrier slot holds an expected word count and a completed word count. The expected count grows when a command is taken up by the walker, and the completed count grows with each scratchpad write. The slot's phase bit toggles once the two counts meet. A consumer watches the phase bit of its slot and touches the tile only after the toggle. With two slots, tile k+1 can be filling while tile k is being read.

Top module: `tile_copy_engine`

## Requirements
- R1: `cmd_ready` is high whenever fewer than two commands are waiting in the command queue and low when two are waiting; a command is accepted on any cycle with both `cmd_valid` and `cmd_ready` high. The walker takes a queued command on the cycle after it becomes idle, so with the read port stalled a third command is still accepted and `cmd_ready` then stays low.
- R2: For a command with source base S, pitch P, tile coordinates (Y, X), height H and width W, the read addresses are S + (Y·H + r)·P + X·W + c, modulo 2^AW. They are issued with c stepping 0..W-1 inside each r, and r stepping 0..H-1.
- R3: On every cycle with `rd_rsp_valid` high, `spad_wr_en` is high in that same cycle and `spad_wr_data` equals `rd_rsp_data`. `spad_wr_addr` is D + r·W + c for the read that the response answers, where D is the destination base.
- R4: With `cmd_swizzle` set, the destination column becomes c XOR (r mod 8), so the address is D + r·W + (c XOR (r mod 8)); this is intended for widths that are multiples of 8. With `cmd_swizzle` clear, the column is c unchanged.
- R5: The phase bit of a barrier slot toggles on the clock edge that follows the scratchpad write of the last word armed on that slot, and it does not toggle earlier.
- R6: `cmd_bar_id` selects the slot (0 or 1) whose `bar_phase` bit reports the tile. A tile completing on one slot leaves the other slot's phase bit unchanged, and no two phase bits toggle on the same edge.
- R7: Commands are processed in acceptance order. Reads of the next tile start as soon as the previous tile's reads are all issued, even while that tile's responses are still outstanding.
- R8: While `rd_req_valid` is high and `rd_req_ready` is low, `rd_req_valid` stays high and `rd_req_addr` stays unchanged on the next cycle.
- R9: A command with zero height or zero width is consumed without issuing any read or scratchpad write and without changing any phase bit.
- R10: At most TAG_DEPTH (default 4) reads are outstanding at any time, and the engine accepts every response, so the read port has no response-ready signal.
- R11: During and right after reset, `cmd_ready` is 1, `rd_req_valid` is 0, `spad_wr_en` is 0 and all phase bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command queue has room |
| cmd_src_base | input | AW | Matrix base address in external memory (words) |
| cmd_pitch | input | AW | Words between consecutive matrix rows |
| cmd_tile_y | input | DIM_W | Tile row coordinate |
| cmd_tile_x | input | DIM_W | Tile column coordinate |
| cmd_rows | input | DIM_W | Tile height in rows |
| cmd_cols | input | DIM_W | Tile width in words |
| cmd_dst_base | input | SAW | Scratchpad destination base |
| cmd_bar_id | input | BIDW | Barrier slot to signal |
| cmd_swizzle | input | 1 | Apply row-XOR column permutation |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Memory accepts the read |
| rd_req_addr | output | AW | Read word address |
| rd_rsp_valid | input | 1 | Read data returned (in order) |
| rd_rsp_data | input | DW | Returned word |
| spad_wr_en | output | 1 | Scratchpad write strobe |
| spad_wr_addr | output | SAW | Scratchpad write address |
| spad_wr_data | output | DW | Scratchpad write word |
| bar_phase | output | NBAR | Phase bit per barrier slot |

## Verification
Four properties are checked on every cycle: a stalled read request holds its address, the count of outstanding reads stays within the tag depth, a phase bit only moves on the edge after a scratchpad write, and at most one slot toggles per edge. The bench scoreboard is the only check on the address arithmetic. It covers row-major source addressing with tile coordinates, destination layout with and without swizzle, and the exact word count at which a barrier toggles. Scenario tests cover the behaviour that depends on ordering or history: the queue filling up while the read port is stalled, the next tile's reads overlapping the previous tile's responses, and empty tiles that leave no trace.

// File: rtl/tce_pkg.sv
package tce_pkg;
  typedef enum logic {
    GEN_IDLE = 1'b0,
    GEN_RUN  = 1'b1
  } gen_state_e;

  // number of low row-index bits folded into the destination column
  localparam int SWZ_BITS = 3;
endpackage

// File: rtl/tce_fifo.sv
module tce_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] pop_data,
  output logic         full,
  output logic         empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp_q, wp_n, rp_q, rp_n;
  logic [PW:0]   cnt_q, cnt_n;
  logic          do_push, do_pop;

  assign full    = (cnt_q == (PW+1)'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign pop_data = mem[rp_q];

  always_comb begin
    wp_n  = wp_q;
    rp_n  = rp_q;
    cnt_n = cnt_q;
    if (do_push) wp_n = wp_q + PW'(1);
    if (do_pop)  rp_n = rp_q + PW'(1);
    if (do_push && !do_pop) cnt_n = cnt_q + (PW+1)'(1);
    if (do_pop && !do_push) cnt_n = cnt_q - (PW+1)'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (do_push || do_pop) begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= push_data;
  end
endmodule

// File: rtl/tce_addr_gen.sv
module tce_addr_gen
  import tce_pkg::*;
#(
  parameter int AW    = 16,
  parameter int SAW   = 10,
  parameter int DIM_W = 6,
  parameter int BIDW  = 1,
  parameter int CNT_W = 2*DIM_W+1
) (
  input  logic             clk,
  input  logic             rst_n,
  // queued command
  input  logic             cmd_avail,
  output logic             cmd_pop,
  input  logic [AW-1:0]    c_src,
  input  logic [AW-1:0]    c_pitch,
  input  logic [DIM_W-1:0] c_ty,
  input  logic [DIM_W-1:0] c_tx,
  input  logic [DIM_W-1:0] c_rows,
  input  logic [DIM_W-1:0] c_cols,
  input  logic [SAW-1:0]   c_dst,
  input  logic [BIDW-1:0]  c_bar,
  input  logic             c_swz,
  // read request port
  output logic             rd_req_valid,
  input  logic             rd_req_ready,
  output logic [AW-1:0]    rd_req_addr,
  // in-flight tag queue
  input  logic             tag_full,
  output logic             tag_push,
  output logic [SAW-1:0]   tag_dst,
  output logic [BIDW-1:0]  tag_bar,
  // barrier arming
  output logic             arm_en,
  output logic [BIDW-1:0]  arm_id,
  output logic [CNT_W-1:0] arm_cnt
);
  gen_state_e       state_q, state_n;
  logic [DIM_W-1:0] r_q, r_n, c_q, c_n;
  logic [DIM_W-1:0] rows_q, cols_q;
  logic [AW-1:0]    pitch_q, row_ptr_q, row_ptr_n;
  logic [SAW-1:0]   dst_row_q, dst_row_n;
  logic [BIDW-1:0]  bar_q;
  logic             swz_q;

  logic             empty_tile, load_en, fire, last_col, last_row;
  logic [AW-1:0]    start_addr;
  logic [DIM_W-1:0] swz_mask, col_phys;

  assign empty_tile = (c_rows == '0) || (c_cols == '0);
  assign cmd_pop    = (state_q == GEN_IDLE) && cmd_avail;
  assign load_en    = cmd_pop && !empty_tile;

  assign arm_en  = load_en;
  assign arm_id  = c_bar;
  assign arm_cnt = CNT_W'(c_rows) * CNT_W'(c_cols);

  // corner of the tile inside the source matrix
  assign start_addr = c_src + (AW'(c_ty) * AW'(c_rows)) * c_pitch
                    + AW'(c_tx) * AW'(c_cols);

  assign rd_req_valid = (state_q == GEN_RUN) && !tag_full;
  assign fire         = rd_req_valid && rd_req_ready;
  assign rd_req_addr  = row_ptr_q + AW'(c_q);

  assign swz_mask = swz_q ? DIM_W'(r_q[SWZ_BITS-1:0]) : '0;
  assign col_phys = c_q ^ swz_mask;
  assign tag_push = fire;
  assign tag_dst  = dst_row_q + SAW'(col_phys);
  assign tag_bar  = bar_q;

  assign last_col = (c_q == cols_q - DIM_W'(1));
  assign last_row = (r_q == rows_q - DIM_W'(1));

  always_comb begin
    state_n   = state_q;
    r_n       = r_q;
    c_n       = c_q;
    row_ptr_n = row_ptr_q;
    dst_row_n = dst_row_q;
    if (load_en) begin
      state_n   = GEN_RUN;
      r_n       = '0;
      c_n       = '0;
      row_ptr_n = start_addr;
      dst_row_n = c_dst;
    end else if (fire) begin
      if (last_col) begin
        c_n       = '0;
        r_n       = r_q + DIM_W'(1);
        row_ptr_n = row_ptr_q + pitch_q;
        dst_row_n = dst_row_q + SAW'(cols_q);
        if (last_row) state_n = GEN_IDLE;
      end else begin
        c_n = c_q + DIM_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= GEN_IDLE;
      r_q       <= '0;
      c_q       <= '0;
      row_ptr_q <= '0;
      dst_row_q <= '0;
    end else if (load_en || fire) begin
      state_q   <= state_n;
      r_q       <= r_n;
      c_q       <= c_n;
      row_ptr_q <= row_ptr_n;
      dst_row_q <= dst_row_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rows_q  <= '0;
      cols_q  <= '0;
      pitch_q <= '0;
      bar_q   <= '0;
      swz_q   <= 1'b0;
    end else if (load_en) begin
      rows_q  <= c_rows;
      cols_q  <= c_cols;
      pitch_q <= c_pitch;
      bar_q   <= c_bar;
      swz_q   <= c_swz;
    end
  end
endmodule

// File: rtl/tce_barrier_bank.sv
module tce_barrier_bank #(
  parameter int NBAR  = 2,
  parameter int BIDW  = 1,
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_en,
  input  logic [BIDW-1:0]  arm_id,
  input  logic [CNT_W-1:0] arm_cnt,
  input  logic             done_en,
  input  logic [BIDW-1:0]  done_id,
  output logic [NBAR-1:0]  phase
);
  localparam int SW = CNT_W + 1;

  for (genvar g = 0; g < NBAR; g++) begin : g_slot
    logic [SW-1:0] exp_q, exp_n, don_q, don_n;
    logic          ph_q, ph_n;
    logic          arm_hit, done_hit, slot_en;

    assign arm_hit  = arm_en  && (arm_id  == BIDW'(g));
    assign done_hit = done_en && (done_id == BIDW'(g));
    assign slot_en  = arm_hit || done_hit;

    always_comb begin
      exp_n = exp_q + (arm_hit ? SW'(arm_cnt) : '0);
      don_n = don_q + (done_hit ? SW'(1) : '0);
      ph_n  = ph_q;
      if ((exp_n != '0) && (exp_n == don_n)) begin
        ph_n  = !ph_q;
        exp_n = '0;
        don_n = '0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        exp_q <= '0;
        don_q <= '0;
        ph_q  <= 1'b0;
      end else if (slot_en) begin
        exp_q <= exp_n;
        don_q <= don_n;
        ph_q  <= ph_n;
      end
    end

    assign phase[g] = ph_q;
  end
endmodule

// File: rtl/tile_copy_engine.sv
module tile_copy_engine #(
  parameter int AW        = 16,
  parameter int DW        = 32,
  parameter int SAW       = 10,
  parameter int DIM_W     = 6,
  parameter int NBAR      = 2,
  parameter int CMD_DEPTH = 2,
  parameter int TAG_DEPTH = 4,
  parameter int BIDW      = (NBAR > 1) ? $clog2(NBAR) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [AW-1:0]    cmd_src_base,
  input  logic [AW-1:0]    cmd_pitch,
  input  logic [DIM_W-1:0] cmd_tile_y,
  input  logic [DIM_W-1:0] cmd_tile_x,
  input  logic [DIM_W-1:0] cmd_rows,
  input  logic [DIM_W-1:0] cmd_cols,
  input  logic [SAW-1:0]   cmd_dst_base,
  input  logic [BIDW-1:0]  cmd_bar_id,
  input  logic             cmd_swizzle,
  output logic             rd_req_valid,
  input  logic             rd_req_ready,
  output logic [AW-1:0]    rd_req_addr,
  input  logic             rd_rsp_valid,
  input  logic [DW-1:0]    rd_rsp_data,
  output logic             spad_wr_en,
  output logic [SAW-1:0]   spad_wr_addr,
  output logic [DW-1:0]    spad_wr_data,
  output logic [NBAR-1:0]  bar_phase
);
  localparam int CMD_W = 2*AW + 4*DIM_W + SAW + BIDW + 1;
  localparam int TAG_W = SAW + BIDW;
  localparam int CNT_W = 2*DIM_W + 1;

  logic [CMD_W-1:0] cmd_in, cmd_q;
  logic             cmd_full, cmd_empty, cmd_pop;
  logic [AW-1:0]    q_src, q_pitch;
  logic [DIM_W-1:0] q_ty, q_tx, q_rows, q_cols;
  logic [SAW-1:0]   q_dst;
  logic [BIDW-1:0]  q_bar;
  logic             q_swz;

  logic             tag_full, tag_empty, tag_push;
  logic [SAW-1:0]   tag_dst, head_dst;
  logic [BIDW-1:0]  tag_bar, head_bar;
  logic             arm_en;
  logic [BIDW-1:0]  arm_id;
  logic [CNT_W-1:0] arm_cnt;

  assign cmd_in = {cmd_src_base, cmd_pitch, cmd_tile_y, cmd_tile_x,
                   cmd_rows, cmd_cols, cmd_dst_base, cmd_bar_id, cmd_swizzle};
  assign {q_src, q_pitch, q_ty, q_tx, q_rows, q_cols, q_dst, q_bar, q_swz} = cmd_q;
  assign cmd_ready = !cmd_full;

  tce_fifo #(.W(CMD_W), .DEPTH(CMD_DEPTH)) u_cmd_q (
    .clk(clk), .rst_n(rst_n),
    .push(cmd_valid), .push_data(cmd_in),
    .pop(cmd_pop), .pop_data(cmd_q),
    .full(cmd_full), .empty(cmd_empty)
  );

  tce_addr_gen #(.AW(AW), .SAW(SAW), .DIM_W(DIM_W), .BIDW(BIDW), .CNT_W(CNT_W)) u_gen (
    .clk(clk), .rst_n(rst_n),
    .cmd_avail(!cmd_empty), .cmd_pop(cmd_pop),
    .c_src(q_src), .c_pitch(q_pitch), .c_ty(q_ty), .c_tx(q_tx),
    .c_rows(q_rows), .c_cols(q_cols), .c_dst(q_dst), .c_bar(q_bar), .c_swz(q_swz),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .tag_full(tag_full), .tag_push(tag_push), .tag_dst(tag_dst), .tag_bar(tag_bar),
    .arm_en(arm_en), .arm_id(arm_id), .arm_cnt(arm_cnt)
  );

  tce_fifo #(.W(TAG_W), .DEPTH(TAG_DEPTH)) u_tag_q (
    .clk(clk), .rst_n(rst_n),
    .push(tag_push), .push_data({tag_dst, tag_bar}),
    .pop(rd_rsp_valid), .pop_data({head_dst, head_bar}),
    .full(tag_full), .empty(tag_empty)
  );

  // responses arrive in order: the head tag names the word being returned
  assign spad_wr_en   = rd_rsp_valid && !tag_empty;
  assign spad_wr_addr = head_dst;
  assign spad_wr_data = rd_rsp_data;

  tce_barrier_bank #(.NBAR(NBAR), .BIDW(BIDW), .CNT_W(CNT_W)) u_bars (
    .clk(clk), .rst_n(rst_n),
    .arm_en(arm_en), .arm_id(arm_id), .arm_cnt(arm_cnt),
    .done_en(spad_wr_en), .done_id(head_bar),
    .phase(bar_phase)
  );
endmodule

// File: rtl/tce_checker.sv
module tce_checker #(
  parameter int AW        = 16,
  parameter int NBAR      = 2,
  parameter int TAG_DEPTH = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rd_req_valid,
  input logic            rd_req_ready,
  input logic [AW-1:0]   rd_req_addr,
  input logic            rd_rsp_valid,
  input logic            spad_wr_en,
  input logic [NBAR-1:0] bar_phase
);
  logic [7:0] outst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outst_q <= '0;
    else if ((rd_req_valid && rd_req_ready) != rd_rsp_valid)
      outst_q <= rd_rsp_valid ? outst_q - 8'd1 : outst_q + 8'd1;
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr)); // R8

  AST_OUTSTANDING_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    outst_q <= 8'(TAG_DEPTH)); // R10

  AST_PHASE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bar_phase != $past(bar_phase)) |-> $past(spad_wr_en)); // R5

  AST_ONE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bar_phase ^ $past(bar_phase))); // R6
endmodule

bind tile_copy_engine tce_checker #(.AW(AW), .NBAR(NBAR), .TAG_DEPTH(TAG_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
  .rd_rsp_valid(rd_rsp_valid), .spad_wr_en(spad_wr_en), .bar_phase(bar_phase)
);

// File: tb/tile_copy_engine_tb_top.sv
module tile_copy_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16, DW = 32, SAW = 10, DIM_W = 6, NBAR = 2, TAG_DEPTH = 4;

  logic             clk, rst_n;
  logic             cmd_valid, cmd_ready;
  logic [AW-1:0]    cmd_src_base, cmd_pitch;
  logic [DIM_W-1:0] cmd_tile_y, cmd_tile_x, cmd_rows, cmd_cols;
  logic [SAW-1:0]   cmd_dst_base;
  logic [0:0]       cmd_bar_id;
  logic             cmd_swizzle;
  logic             rd_req_valid, rd_req_ready;
  logic [AW-1:0]    rd_req_addr;
  logic             rd_rsp_valid;
  logic [DW-1:0]    rd_rsp_data;
  logic             spad_wr_en;
  logic [SAW-1:0]   spad_wr_addr;
  logic [DW-1:0]    spad_wr_data;
  logic [NBAR-1:0]  bar_phase;

  tile_copy_engine dut_i (.*);

  int checks = 0, failures = 0;
  logic [AW-1:0]  exp_rd[$];
  logic [SAW-1:0] exp_wa[$];
  logic [DW-1:0]  exp_wd[$];
  int             exp_wb[$];
  logic [AW-1:0]  pend[$];
  int bar_target[NBAR], bar_done[NBAR], flips[NBAR];
  int rd_count = 0, outst = 0;
  logic [NBAR-1:0] ph_prev;
  logic hold_pend;
  logic [AW-1:0] hold_addr;
  logic stall_force = 1'b0, rsp_hold = 1'b0;
  logic [15:0] lfsr;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [DW-1:0] memval(input logic [AW-1:0] a);
    return {~a, a};
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // memory model: drives ready and in-order responses just after each edge
  always @(posedge clk) begin
    #1;
    if (!rst_n) begin
      rd_req_ready = 1'b0;
      rd_rsp_valid = 1'b0;
    end else begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rd_req_ready = stall_force ? 1'b0 : (lfsr[1] | lfsr[2]);
      if (!rsp_hold && pend.size() > 0 && (lfsr[3] | lfsr[5])) begin
        rd_rsp_valid = 1'b1;
        rd_rsp_data  = memval(pend.pop_front());
      end else begin
        rd_rsp_valid = 1'b0;
      end
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      for (int b = 0; b < NBAR; b++) begin
        if (bar_phase[b] != ph_prev[b]) begin
          chk(bar_done[b] == bar_target[b] && bar_target[b] != 0,
              $sformatf("R5 words written at toggle, slot %0d", b), bar_done[b], bar_target[b]);
          flips[b]++;
          bar_done[b] = 0;
          bar_target[b] = 0;
        end
      end
      ph_prev = bar_phase;
      if (hold_pend && rd_req_valid)
        chk(rd_req_addr == hold_addr, "R8 stalled address held", rd_req_addr, hold_addr);
      hold_pend = rd_req_valid && !rd_req_ready;
      hold_addr = rd_req_addr;
      if (rd_req_valid && rd_req_ready) begin
        if (exp_rd.size() == 0) chk(1'b0, "R2 unexpected read", rd_req_addr, 0);
        else begin
          logic [AW-1:0] e;
          e = exp_rd.pop_front();
          chk(rd_req_addr == e, "R2 read address", rd_req_addr, e);
        end
        pend.push_back(rd_req_addr);
        rd_count++;
        outst++;
      end
      chk(spad_wr_en == rd_rsp_valid, "R3 write strobe follows response", spad_wr_en, rd_rsp_valid);
      if (spad_wr_en) begin
        if (exp_wa.size() == 0) chk(1'b0, "R3 unexpected write", spad_wr_addr, 0);
        else begin
          logic [SAW-1:0] ea;
          logic [DW-1:0]  ed;
          int eb;
          ea = exp_wa.pop_front();
          ed = exp_wd.pop_front();
          eb = exp_wb.pop_front();
          chk(spad_wr_addr == ea, "R3/R4 scratchpad address", spad_wr_addr, ea);
          chk(spad_wr_data == ed, "R3 scratchpad data", spad_wr_data, ed);
          bar_done[eb]++;
        end
        outst--;
      end
      if (outst > TAG_DEPTH) chk(1'b0, "R10 outstanding reads", outst, TAG_DEPTH);
    end
  end

  task automatic send_cmd(input logic [AW-1:0] src, input logic [AW-1:0] pitch,
                          input int ty, input int tx, input int rows, input int cols,
                          input logic [SAW-1:0] dst, input int bar, input bit swz);
    for (int r = 0; r < rows; r++) begin
      for (int c = 0; c < cols; c++) begin
        logic [AW-1:0] a;
        int pc;
        a  = AW'(src + (ty*rows + r)*pitch + tx*cols + c);
        pc = swz ? (c ^ (r % 8)) : c;
        exp_rd.push_back(a);
        exp_wa.push_back(SAW'(dst + r*cols + pc));
        exp_wd.push_back(memval(a));
        exp_wb.push_back(bar);
      end
    end
    if (rows != 0 && cols != 0) bar_target[bar] += rows*cols;
    @(posedge clk); #2;
    cmd_valid = 1'b1;
    cmd_src_base = src; cmd_pitch = pitch;
    cmd_tile_y = DIM_W'(ty); cmd_tile_x = DIM_W'(tx);
    cmd_rows = DIM_W'(rows); cmd_cols = DIM_W'(cols);
    cmd_dst_base = dst; cmd_bar_id = 1'(bar); cmd_swizzle = swz;
    do @(negedge clk); while (!cmd_ready);
    @(posedge clk); #2;
    cmd_valid = 1'b0;
  endtask

  task automatic wait_flips(input int b, input int n, input string tag);
    int k = 0;
    while (flips[b] < n && k < 3000) begin @(negedge clk); k++; end
    chk(flips[b] >= n, tag, flips[b], n);
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int base;
    lfsr = 16'hACE1;
    rst_n = 1'b0; cmd_valid = 1'b0;
    cmd_src_base = '0; cmd_pitch = '0; cmd_tile_y = '0; cmd_tile_x = '0;
    cmd_rows = '0; cmd_cols = '0; cmd_dst_base = '0; cmd_bar_id = '0; cmd_swizzle = 1'b0;
    rd_req_ready = 1'b0; rd_rsp_valid = 1'b0; rd_rsp_data = '0;
    hold_pend = 1'b0; hold_addr = '0; ph_prev = '0;
    for (int b = 0; b < NBAR; b++) begin bar_target[b] = 0; bar_done[b] = 0; flips[b] = 0; end
    repeat (4) @(negedge clk);
    chk(cmd_ready == 1'b1, "R11 cmd_ready in reset", cmd_ready, 1);
    chk(rd_req_valid == 1'b0, "R11 no read in reset", rd_req_valid, 0);
    chk(spad_wr_en == 1'b0, "R11 no write in reset", spad_wr_en, 0);
    chk(bar_phase == '0, "R11 phases clear", bar_phase, 0);
    @(posedge clk); #2 rst_n = 1'b1;

    // plain tile, slot 0, with tile coordinates
    send_cmd(16'h0100, 16'd32, 1, 2, 3, 4, 10'h010, 0, 1'b0);
    wait_flips(0, 1, "R5 slot 0 completes");
    @(negedge clk);
    chk(bar_phase == 2'b01, "R6 only slot 0 toggled", bar_phase, 2'b01);

    // swizzled tile, slot 1
    send_cmd(16'h0400, 16'd64, 0, 0, 4, 8, 10'h080, 1, 1'b1);
    wait_flips(1, 1, "R4 swizzled tile completes on slot 1");
    @(negedge clk);
    chk(bar_phase == 2'b11, "R6 slot 1 toggled, slot 0 kept", bar_phase, 2'b11);

    // pipelining: second tile reads start before first tile completes
    rsp_hold = 1'b1;
    base = rd_count;
    send_cmd(16'h1000, 16'd16, 2, 1, 1, 3, 10'h100, 0, 1'b0);
    send_cmd(16'h2000, 16'd20, 0, 3, 2, 2, 10'h140, 1, 1'b0);
    repeat (40) @(negedge clk);
    chk(rd_count - base == TAG_DEPTH, "R7/R10 reads issued with responses held", rd_count - base, TAG_DEPTH);
    chk(flips[0] == 1, "R7 first tile still pending", flips[0], 1);
    rsp_hold = 1'b0;
    wait_flips(0, 2, "R7 first tile completes");
    wait_flips(1, 2, "R7 second tile completes");

    // queue fills while the read port is stalled
    stall_force = 1'b1;
    send_cmd(16'h3000, 16'd8, 0, 0, 2, 3, 10'h200, 0, 1'b0);
    send_cmd(16'h3100, 16'd8, 1, 1, 2, 2, 10'h240, 1, 1'b1);
    send_cmd(16'h3200, 16'd8, 0, 0, 0, 4, 10'h280, 0, 1'b0);
    @(negedge clk);
    chk(cmd_ready == 1'b0, "R1 queue full drops ready", cmd_ready, 0);
    repeat (5) @(negedge clk);
    chk(cmd_ready == 1'b0, "R1 ready stays low while stalled", cmd_ready, 0);
    stall_force = 1'b0;
    wait_flips(0, 3, "R1 first queued tile completes");
    wait_flips(1, 3, "R1 second queued tile completes");
    repeat (20) @(negedge clk);
    chk(cmd_ready == 1'b1, "R1 ready back after drain", cmd_ready, 1);

    // empty tile: nothing happens
    base = rd_count;
    send_cmd(16'h4000, 16'd8, 0, 0, 3, 0, 10'h300, 1, 1'b0);
    repeat (20) @(negedge clk);
    chk(rd_count == base, "R9 empty tile issues no read", rd_count, base);
    chk(bar_phase == 2'b11, "R9 phases unchanged", bar_phase, 2'b11);

    chk(exp_rd.size() == 0, "R2 all reads seen", exp_rd.size(), 0);
    chk(exp_wa.size() == 0, "R3 all writes seen", exp_wa.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule